// File: doc/BRIEF.md
# DSP Saturation and Flag Unit

This combinational block sits after a 40-bit DSP arithmetic datapath. The raw result holds 32 data bits below 8 guard bits, all in two's complement. The block produces the value written to the destination register, the overflow flag and the DC flag.

A result overflows when it does not fit the 32-bit range with the guard bits left out. When the status-register saturation enable is set, an overflowing result is clamped to the nearest limit and both flags are held clear. There are two clamping rules, one for fixed-point results and one for integer (upper-word) results. When saturation is off, the raw value passes through unchanged and the flags report the overflow.

Top module: `dsp_sat_flags`

## Requirements
- R1: With `sat_en` = 0 the destination equals the raw result bit for bit, for either operation type.
- R2: With `sat_en` = 0, `ovf_v` is 1 exactly when raw bits [39:31] are not all equal, and 0 otherwise.
- R3: With `sat_en` = 1 and `int_op` = 0, a positive overflowing result (bit 39 = 0, bits [39:31] not all equal) gives H'00_7FFF_FFFF.
- R4: With `sat_en` = 1 and either `int_op` value, a negative overflowing result (bit 39 = 1, bits [39:31] not all equal) gives H'FF_8000_0000.
- R5: With `sat_en` = 1 and `int_op` = 1, a positive overflowing result gives H'00_7FFF_0000, so the low 16 bits are zero.
- R6: With `sat_en` = 1 and a result inside the range (bits [39:31] all equal), the destination equals the raw result. This includes both exact limits.
- R7: With `sat_en` = 1, `ovf_v` and `dc_flag` are both 0 for every input.
- R8: `cond_sel` = 3'b011 selects overflow mode, in which `dc_flag` equals `ovf_v`. Every other `cond_sel` code gives `dc_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| raw_res | input | 40 | Raw result: guard bits [39:32], data bits [31:0] |
| int_op | input | 1 | 1 = integer (upper-word) operation, 0 = fixed-point |
| sat_en | input | 1 | Saturation enable from the status register |
| cond_sel | input | 3 | Condition select field; 3'b011 = overflow mode |
| dst | output | 40 | Value for the destination register |
| ovf_v | output | 1 | Overflow flag |
| dc_flag | output | 1 | Condition flag, driven here only in overflow mode |

## Verification
Random 40-bit values, mostly overflowing, separate the pass-through path from the clamp path. Values drawn inside the range show that saturation leaves legal results alone. Four directed values sit exactly at each limit and one step beyond it, which shows whether the comparison is off by one. Every `cond_sel` code is tried with both `int_op` values and both `sat_en` settings, which separates the fixed-point rule from the integer rule and shows that DC follows V only in overflow mode.

// File: rtl/dsp_sat_flags.sv
module dsp_sat_flags #(
  parameter int          GUARD_W  = 8,
  parameter int          DATA_W   = 32,
  parameter int          LOW_W    = 16,
  parameter logic [2:0]  OVF_MODE = 3'b011
) (
  input  logic [GUARD_W+DATA_W-1:0] raw_res,
  input  logic                      int_op,
  input  logic                      sat_en,
  input  logic [2:0]                cond_sel,
  output logic [GUARD_W+DATA_W-1:0] dst,
  output logic                      ovf_v,
  output logic                      dc_flag
);
  localparam int W = GUARD_W + DATA_W;
  localparam logic [W-1:0] POS_LIM  = {{(GUARD_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM  = {{(GUARD_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic [W-1:0] LOW_MASK = {{(W-LOW_W){1'b1}}, {LOW_W{1'b0}}};

  logic [GUARD_W:0] sign_field;
  logic             out_of_range;
  logic [W-1:0]     clamp_val;

  assign sign_field   = raw_res[W-1:DATA_W-1];
  assign out_of_range = !((&sign_field) || !(|sign_field));

  always_comb begin
    if (raw_res[W-1]) clamp_val = NEG_LIM;
    else if (int_op)  clamp_val = POS_LIM & LOW_MASK;
    else              clamp_val = POS_LIM;
  end

  assign dst     = (sat_en && out_of_range) ? clamp_val : raw_res;
  assign ovf_v   = out_of_range && !sat_en;
  assign dc_flag = (cond_sel == OVF_MODE) ? ovf_v : 1'b0;

  always_comb begin
    if (!sat_en) assert_pass_through_R1: assert (dst == raw_res);
    if (sat_en) assert_in_range_R6: assert ((&dst[W-1:DATA_W-1]) || !(|dst[W-1:DATA_W-1]));
    if (sat_en && out_of_range) assert_sign_kept_R4: assert (dst[W-1] == raw_res[W-1]);
    assert_flags_clear_R7: assert (!(sat_en && (ovf_v || dc_flag)));
    if (dc_flag) assert_dc_mode_R8: assert (cond_sel == OVF_MODE && ovf_v);
  end
endmodule

// File: tb/sim_dsp_sat_flags.sv
module sim_dsp_sat_flags;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [39:0] raw_res;
  logic        int_op, sat_en;
  logic [2:0]  cond_sel;
  logic [39:0] dst;
  logic        ovf_v, dc_flag;
  int checks = 0, fails = 0;
  bit done = 0;

  dsp_sat_flags u0 (.raw_res(raw_res), .int_op(int_op), .sat_en(sat_en),
                    .cond_sel(cond_sel), .dst(dst), .ovf_v(ovf_v), .dc_flag(dc_flag));

  function automatic bit ovf_of(input logic [39:0] r);
    return !((&r[39:31]) || !(|r[39:31]));
  endfunction

  function automatic logic [39:0] exp_dst(input logic [39:0] r, input bit io, input bit se);
    if (!se || !ovf_of(r)) return r;
    if (r[39]) return 40'hFF_8000_0000;
    return io ? 40'h00_7FFF_0000 : 40'h00_7FFF_FFFF;
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s raw=%h int=%0b sat=%0b cs=%0d actual=%h expected=%h",
               req, raw_res, int_op, sat_en, cond_sel, act, exp);
    end
  endtask

  task automatic apply(input logic [39:0] r, input bit io, input bit se, input logic [2:0] cs);
    logic [39:0] e;
    bit ev;
    string rq;
    @(posedge clk);
    raw_res = r; int_op = io; sat_en = se; cond_sel = cs;
    @(negedge clk);
    e  = exp_dst(r, io, se);
    ev = ovf_of(r) && !se;
    if (!se) rq = "R1";
    else if (!ovf_of(r)) rq = "R6";
    else if (r[39]) rq = "R4";
    else rq = io ? "R5" : "R3";
    chk(rq, dst, e);
    chk(se ? "R7" : "R2", {39'd0, ovf_v}, {39'd0, ev});
    chk("R8", {39'd0, dc_flag}, {39'd0, (cs == 3'b011) ? ev : 1'b0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [39:0] r;
    void'($urandom(32'd1234));
    raw_res = '0; int_op = 0; sat_en = 0; cond_sel = 3'b011;
    @(negedge clk);
    chk("R1", dst, 40'd0);
    chk("R2", {39'd0, ovf_v}, 40'd0);
    for (int io = 0; io < 2; io++)
      for (int se = 0; se < 2; se++)
        for (int cs = 0; cs < 8; cs++) begin
          apply(40'h00_7FFF_FFFF, io[0], se[0], cs[2:0]);
          apply(40'h00_8000_0000, io[0], se[0], cs[2:0]);
          apply(40'hFF_8000_0000, io[0], se[0], cs[2:0]);
          apply(40'hFF_7FFF_FFFF, io[0], se[0], cs[2:0]);
        end
    for (int i = 0; i < 2000; i++) begin
      r = {$urandom(), $urandom()};
      case ($urandom_range(0, 3))
        0: r[39:31] = r[39] ? 9'h1FF : 9'h000;
        1: r[39:32] = $urandom_range(0, 1) ? 8'h00 : 8'hFF;
        default: ;
      endcase
      apply(r, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule